// File: doc/BRIEF.md
# Runahead Mode Controller

This controller sits beside a simple in-order pipeline and decides when the core leaves normal execution for a speculative pre-execution mode, and when it comes back. When a level-one instruction or data cache miss arrives in normal mode, the controller does four things. It records the instruction address of the faulting access and the line it missed on. It asks for a demand fill of that line unless a fill is already in flight. It pulses a register checkpoint command. It raises its speculative-mode flag.

While speculative mode is active, store write enables are held low. Stores still compute addresses and probe the cache, but nothing is written. Any new miss is turned into a prefetch request, except a miss to the line being filled or to a line that already has a fill outstanding. When the fill for the recorded line completes, the controller pulses a checkpoint restore and a fetch redirect to the recorded address, both in the same cycle. It drops speculative mode on the next cycle.

When a load caused the entry, the controller also asks the pipeline to mark that load's destination register as invalid. The caches, the register file and the pipeline datapath are outside this block.

Top module: `ra_ctrl`

## Requirements
- R1: After reset every output pulse is low and `ra_mode` is low. A data or instruction miss strobe seen in normal mode raises `ra_mode` on the next cycle.
- R2: One cycle after an entering miss, `demand_vld` pulses for one cycle with that miss's line address. It stays low when the miss's in-flight flag is set.
- R3: One cycle after an entering miss, `ckpt_save` pulses for exactly one cycle.
- R4: `st_we` equals `st_req` whenever `ra_mode` is low, and it is low in every cycle where `ra_mode` is high.
- R5: A miss seen while in runahead (not the exit cycle) produces a one-cycle `pf_vld` on the next cycle with its line. No prefetch is produced when the miss's line equals the recorded line or when its in-flight flag is set.
- R6: A `fill_done` whose `fill_line` equals the recorded line, seen during runahead, makes `ckpt_restore` and `redirect_vld` high together for one cycle on the next cycle. `ra_mode` falls on the cycle after that.
- R7: When the entering miss came from the data port with `dmiss_load` = 1, `inv_vld` pulses with the entering cycle's `dmiss_dst` at the same time as `ckpt_save`. Store misses and instruction misses leave `inv_vld` low.
- R8: `redirect_pc` shows the recorded faulting address. Misses during runahead neither re-enter nor change it.
- R9: A `fill_done` for any other line, or a `fill_done` seen in normal mode, causes no restore, no redirect and no mode change.
- R10: When both miss strobes are high in one cycle, the data miss is taken, both for entry and for prefetch, and the instruction miss is dropped.
- R11: Misses seen in the cycle where `ckpt_restore` is high produce neither a prefetch nor a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmiss_vld | input | 1 | Data cache miss strobe |
| dmiss_pc | input | PC_W | Instruction address of the missing load/store |
| dmiss_line | input | LINE_W | Line address of the data miss |
| dmiss_load | input | 1 | Miss came from a load (1) or a store (0) |
| dmiss_dst | input | REG_W | Destination register of the missing load |
| dmiss_busy | input | 1 | A fill for this data line is already in flight |
| imiss_vld | input | 1 | Instruction cache miss strobe |
| imiss_pc | input | PC_W | Fetch address that missed |
| imiss_line | input | LINE_W | Line address of the instruction miss |
| imiss_busy | input | 1 | A fill for this instruction line is already in flight |
| fill_done | input | 1 | A line fill completed |
| fill_line | input | LINE_W | Line address of the completed fill |
| st_req | input | 1 | Pipeline store write request |
| ra_mode | output | 1 | High while the core runs ahead (including the exit cycle) |
| ckpt_save | output | 1 | Register checkpoint command |
| ckpt_restore | output | 1 | Register checkpoint restore command |
| redirect_vld | output | 1 | Fetch redirect strobe |
| redirect_pc | output | PC_W | Recorded faulting address |
| demand_vld | output | 1 | Demand fill request |
| demand_line | output | LINE_W | Line for the demand fill |
| pf_vld | output | 1 | Prefetch request |
| pf_line | output | LINE_W | Line for the prefetch |
| inv_vld | output | 1 | Mark-invalid request for a register |
| inv_reg | output | REG_W | Register to mark invalid |
| st_we | output | 1 | Store write enable to memory |

## Verification
A corrupted recorded line shows up in two ways. Prefetches to the line being filled leak out on the next runahead miss, and the exit is either missed or taken early on a fill for the wrong line. A corrupted mode state shows up within one cycle as `st_we` passing a store during runahead, or as a missing or doubled checkpoint or restore pulse. A recorded address overwritten by a later miss stays invisible until exit and then appears as a wrong `redirect_pc`. For that reason the scenarios drive several runahead misses with new addresses before every exit.

// File: rtl/ra_pkg.sv
package ra_pkg;

  // Mode of the controller. Normal -> run ahead -> one exit cycle -> normal.
  typedef enum logic [1:0] {
    RA_NORM = 2'd0,
    RA_RUN  = 2'd1,
    RA_EXIT = 2'd2
  } ra_state_e;

endpackage

// File: rtl/ra_miss_arb.sv
// Picks one miss per cycle; the data side is older in the pipe and wins.
module ra_miss_arb #(
  parameter int PC_W   = 32,
  parameter int LINE_W = 26,
  parameter int REG_W  = 5
) (
  input  logic              d_vld,
  input  logic [PC_W-1:0]   d_pc,
  input  logic [LINE_W-1:0] d_line,
  input  logic              d_load,
  input  logic [REG_W-1:0]  d_dst,
  input  logic              d_busy,
  input  logic              i_vld,
  input  logic [PC_W-1:0]   i_pc,
  input  logic [LINE_W-1:0] i_line,
  input  logic              i_busy,
  output logic              m_vld,
  output logic [PC_W-1:0]   m_pc,
  output logic [LINE_W-1:0] m_line,
  output logic              m_load,
  output logic [REG_W-1:0]  m_dst,
  output logic              m_busy
);

  always_comb begin
    m_vld = d_vld | i_vld;
    if (d_vld) begin
      m_pc   = d_pc;
      m_line = d_line;
      m_load = d_load;
      m_dst  = d_dst;
      m_busy = d_busy;
    end else begin
      m_pc   = i_pc;
      m_line = i_line;
      m_load = 1'b0;
      m_dst  = '0;
      m_busy = i_busy;
    end
  end

endmodule

// File: rtl/ra_origin.sv
// Holds the faulting address and line of the miss that started runahead.
module ra_origin #(
  parameter int PC_W   = 32,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [PC_W-1:0]   cap_pc,
  input  logic [LINE_W-1:0] cap_line,
  input  logic              fill_done,
  input  logic [LINE_W-1:0] fill_line,
  output logic [PC_W-1:0]   o_pc,
  output logic [LINE_W-1:0] o_line,
  output logic              fill_hit
);

  logic [PC_W-1:0]   pc_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    pc_d   = o_pc;
    line_d = o_line;
    if (cap_en) begin
      pc_d   = cap_pc;
      line_d = cap_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_pc   <= '0;
      o_line <= '0;
    end else begin
      o_pc   <= pc_d;
      o_line <= line_d;
    end
  end

  assign fill_hit = fill_done & (fill_line == o_line);

  // R8: the record only moves on a capture
  p_hold_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_en) |-> ($stable(o_pc) && $stable(o_line)));

endmodule

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      miss_vld,
  input  logic      fill_hit,
  output ra_state_e state_q,
  output logic      enter,
  output logic      in_run
);

  ra_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RA_NORM: if (miss_vld) state_d = RA_RUN;
      RA_RUN:  if (fill_hit) state_d = RA_EXIT;
      RA_EXIT: state_d = RA_NORM;
      default: state_d = RA_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RA_NORM;
    else        state_q <= state_d;
  end

  assign enter  = (state_q == RA_NORM) & miss_vld;
  assign in_run = (state_q == RA_RUN);

  // R6: the exit cycle is only reached from runahead
  p_exit_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RA_EXIT) |-> ($past(state_q) == RA_RUN));

endmodule

// File: rtl/ra_req_gen.sv
// Registered request pulses: checkpoint, demand fill, prefetch, invalid mark.
module ra_req_gen #(
  parameter int LINE_W = 26,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              in_run,
  input  logic              m_vld,
  input  logic [LINE_W-1:0] m_line,
  input  logic              m_load,
  input  logic [REG_W-1:0]  m_dst,
  input  logic              m_busy,
  input  logic [LINE_W-1:0] o_line,
  output logic              save_q,
  output logic              dem_q,
  output logic [LINE_W-1:0] dem_line_q,
  output logic              pf_q,
  output logic [LINE_W-1:0] pf_line_q,
  output logic              inv_q,
  output logic [REG_W-1:0]  inv_reg_q
);

  logic              save_d, dem_d, pf_d, inv_d;
  logic [LINE_W-1:0] dem_line_d, pf_line_d;
  logic [REG_W-1:0]  inv_reg_d;

  always_comb begin
    save_d     = enter;
    dem_d      = enter & ~m_busy;
    inv_d      = enter & m_load;
    pf_d       = in_run & m_vld & ~m_busy & (m_line != o_line);
    dem_line_d = dem_d ? m_line : dem_line_q;
    pf_line_d  = pf_d  ? m_line : pf_line_q;
    inv_reg_d  = inv_d ? m_dst  : inv_reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q     <= 1'b0;
      dem_q      <= 1'b0;
      pf_q       <= 1'b0;
      inv_q      <= 1'b0;
      dem_line_q <= '0;
      pf_line_q  <= '0;
      inv_reg_q  <= '0;
    end else begin
      save_q     <= save_d;
      dem_q      <= dem_d;
      pf_q       <= pf_d;
      inv_q      <= inv_d;
      dem_line_q <= dem_line_d;
      pf_line_q  <= pf_line_d;
      inv_reg_q  <= inv_reg_d;
    end
  end

  // R5: never a prefetch for the line already being filled
  p_pf_not_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> (pf_line_q != o_line));

endmodule

// File: rtl/ra_ctrl.sv
module ra_ctrl
  import ra_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int LINE_W = 26,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmiss_vld,
  input  logic [PC_W-1:0]   dmiss_pc,
  input  logic [LINE_W-1:0] dmiss_line,
  input  logic              dmiss_load,
  input  logic [REG_W-1:0]  dmiss_dst,
  input  logic              dmiss_busy,
  input  logic              imiss_vld,
  input  logic [PC_W-1:0]   imiss_pc,
  input  logic [LINE_W-1:0] imiss_line,
  input  logic              imiss_busy,
  input  logic              fill_done,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              st_req,
  output logic              ra_mode,
  output logic              ckpt_save,
  output logic              ckpt_restore,
  output logic              redirect_vld,
  output logic [PC_W-1:0]   redirect_pc,
  output logic              demand_vld,
  output logic [LINE_W-1:0] demand_line,
  output logic              pf_vld,
  output logic [LINE_W-1:0] pf_line,
  output logic              inv_vld,
  output logic [REG_W-1:0]  inv_reg,
  output logic              st_we
);

  logic              m_vld, m_load, m_busy;
  logic [PC_W-1:0]   m_pc;
  logic [LINE_W-1:0] m_line, o_line;
  logic [REG_W-1:0]  m_dst;
  logic              enter, in_run, fill_hit;
  ra_state_e         state_q;

  ra_miss_arb #(.PC_W(PC_W), .LINE_W(LINE_W), .REG_W(REG_W)) u_arb (
    .d_vld(dmiss_vld), .d_pc(dmiss_pc), .d_line(dmiss_line),
    .d_load(dmiss_load), .d_dst(dmiss_dst), .d_busy(dmiss_busy),
    .i_vld(imiss_vld), .i_pc(imiss_pc), .i_line(imiss_line), .i_busy(imiss_busy),
    .m_vld(m_vld), .m_pc(m_pc), .m_line(m_line), .m_load(m_load),
    .m_dst(m_dst), .m_busy(m_busy)
  );

  ra_origin #(.PC_W(PC_W), .LINE_W(LINE_W)) u_origin (
    .clk(clk), .rst_n(rst_n), .cap_en(enter), .cap_pc(m_pc), .cap_line(m_line),
    .fill_done(fill_done), .fill_line(fill_line),
    .o_pc(redirect_pc), .o_line(o_line), .fill_hit(fill_hit)
  );

  ra_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_vld(m_vld), .fill_hit(fill_hit),
    .state_q(state_q), .enter(enter), .in_run(in_run)
  );

  ra_req_gen #(.LINE_W(LINE_W), .REG_W(REG_W)) u_req (
    .clk(clk), .rst_n(rst_n), .enter(enter), .in_run(in_run),
    .m_vld(m_vld), .m_line(m_line), .m_load(m_load), .m_dst(m_dst),
    .m_busy(m_busy), .o_line(o_line),
    .save_q(ckpt_save), .dem_q(demand_vld), .dem_line_q(demand_line),
    .pf_q(pf_vld), .pf_line_q(pf_line), .inv_q(inv_vld), .inv_reg_q(inv_reg)
  );

  assign ra_mode      = (state_q != RA_NORM);
  assign ckpt_restore = (state_q == RA_EXIT);
  assign redirect_vld = (state_q == RA_EXIT);
  assign st_we        = st_req & (state_q == RA_NORM);

  // R4: stores never reach memory while running ahead
  p_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ra_mode |-> !st_we);

  // R3: entry always carries a single checkpoint pulse
  p_save_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ra_mode) |-> ckpt_save);
  p_save_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |=> !ckpt_save);

  // R2: demand fills only on the entry cycle
  p_demand_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    demand_vld |-> (ra_mode && !$past(ra_mode)));

  // R5: prefetches only appear while in runahead
  p_pf_in_ra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld |-> ra_mode);

  // R6: restore is followed by normal mode
  p_exit_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> (!ra_mode && !ckpt_restore));

  // R7: invalid mark rides with the checkpoint pulse
  p_inv_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> ckpt_save);

  // R8: recorded address steady across runahead
  p_pc_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && $past(ra_mode)) |-> $stable(redirect_pc));

endmodule

// File: tb/tb_ra_ctrl.sv
`timescale 1ns/1ps
module tb_ra_ctrl;
  localparam int PC_W = 32, LINE_W = 26, REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              dmiss_vld = 0, dmiss_load = 0, dmiss_busy = 0;
  logic [PC_W-1:0]   dmiss_pc = '0, imiss_pc = '0;
  logic [LINE_W-1:0] dmiss_line = '0, imiss_line = '0, fill_line = '0;
  logic [REG_W-1:0]  dmiss_dst = '0;
  logic              imiss_vld = 0, imiss_busy = 0, fill_done = 0, st_req = 0;
  logic              ra_mode, ckpt_save, ckpt_restore, redirect_vld;
  logic [PC_W-1:0]   redirect_pc;
  logic              demand_vld, pf_vld, inv_vld, st_we;
  logic [LINE_W-1:0] demand_line, pf_line;
  logic [REG_W-1:0]  inv_reg;

  ra_ctrl #(.PC_W(PC_W), .LINE_W(LINE_W), .REG_W(REG_W)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int        m_state = 0;       // 0 normal, 1 runahead, 2 exit
  longint    m_pc = 0, m_line = 0;
  bit        e_save = 0, e_dem = 0, e_pf = 0, e_inv = 0;
  longint    e_dem_line = 0, e_pf_line = 0, e_inv_reg = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1", "ra_mode", ra_mode, m_state != 0);
    chk("R3", "ckpt_save", ckpt_save, e_save);
    chk("R6", "ckpt_restore", ckpt_restore, m_state == 2);
    chk("R6", "redirect_vld", redirect_vld, m_state == 2);
    if (m_state == 2) chk("R8", "redirect_pc", redirect_pc, m_pc);
    chk("R2", "demand_vld", demand_vld, e_dem);
    if (e_dem) chk("R2", "demand_line", demand_line, e_dem_line);
    chk("R5", "pf_vld", pf_vld, e_pf);
    if (e_pf) chk("R5", "pf_line", pf_line, e_pf_line);
    chk("R7", "inv_vld", inv_vld, e_inv);
    if (e_inv) chk("R7", "inv_reg", inv_reg, e_inv_reg);
    chk("R4", "st_we", st_we, st_req && (m_state == 0));
  endtask

  // advance the model by one clock using the inputs now applied
  task automatic model_step();
    bit     sv, sl, sb;
    longint sp, sln, sd;
    int     nst;
    sv = dmiss_vld | imiss_vld;
    if (dmiss_vld) begin sp = dmiss_pc; sln = dmiss_line; sl = dmiss_load; sd = dmiss_dst; sb = dmiss_busy; end
    else begin sp = imiss_pc; sln = imiss_line; sl = 0; sd = 0; sb = imiss_busy; end
    e_save = 0; e_dem = 0; e_pf = 0; e_inv = 0;
    nst = m_state;
    if (m_state == 0 && sv) begin
      nst = 1; m_pc = sp; m_line = sln; e_save = 1;
      if (!sb) begin e_dem = 1; e_dem_line = sln; end
      if (sl) begin e_inv = 1; e_inv_reg = sd; end
    end else if (m_state == 1) begin
      if (sv && !sb && sln != m_line) begin e_pf = 1; e_pf_line = sln; end
      if (fill_done && fill_line == m_line) nst = 2;
    end else if (m_state == 2) nst = 0;
    m_state = nst;
  endtask

  task automatic cyc(input bit dv, input longint dpc, input longint dln, input bit dld,
                     input longint ddst, input bit dbz, input bit iv, input longint ipc,
                     input longint iln, input bit ibz, input bit fd, input longint fln,
                     input bit st);
    dmiss_vld = dv; dmiss_pc = dpc[PC_W-1:0]; dmiss_line = dln[LINE_W-1:0];
    dmiss_load = dld; dmiss_dst = ddst[REG_W-1:0]; dmiss_busy = dbz;
    imiss_vld = iv; imiss_pc = ipc[PC_W-1:0]; imiss_line = iln[LINE_W-1:0]; imiss_busy = ibz;
    fill_done = fd; fill_line = fln[LINE_W-1:0]; st_req = st;
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit st);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0, 0,0,0,0, 0,0, st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    #1; compare();
    rst_n = 1'b1;
    @(negedge clk);
    idle(2, 1);                                            // R4 stores pass in normal
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'h55,1);                   // R9 fill in normal ignored
    idle(1, 0);
    // load miss entry (R1 R2 R3 R7)
    cyc(1,'h1000,'h40,1,7,0, 0,0,0,0, 0,0,1);
    cyc(0,0,0,0,0,0, 0,0,0,0, 0,0,1);                      // R4 store muted
    cyc(0,0,0,0,0,0, 1,'h2000,'h41,0, 0,0,1);              // R5 prefetch, R8 no re-entry
    cyc(1,'h1100,'h40,1,3,0, 0,0,0,0, 0,0,0);              // R5 origin line: no prefetch
    cyc(1,'h1200,'h42,0,0,1, 0,0,0,0, 0,0,0);              // R5 busy: no prefetch
    cyc(1,'h1300,'h43,0,0,0, 1,'h2100,'h44,0, 0,0,0);      // R10 data wins
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'h41,1);                   // R9 other line ignored
    cyc(0,0,0,0,0,0, 1,'h2200,'h45,0, 1,'h40,1);           // R6 exit + same-cycle prefetch
    cyc(1,'h1400,'h46,1,9,0, 1,'h2300,'h47,0, 0,0,1);      // R11 miss in exit ignored
    idle(2, 1);
    // instruction miss entry with fill already in flight (R2 R7)
    cyc(0,0,0,0,0,0, 1,'h3000,'h80,1, 0,0,0);
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'h80,1);
    idle(3, 1);
    // simultaneous entry: data store miss wins, no invalid mark (R10 R7)
    cyc(1,'h4000,'h90,0,4,0, 1,'h5000,'h91,0, 0,0,0);
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'h91,0);                   // R9 instruction line was dropped
    idle(2, 1);
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'h90,0);
    idle(3, 1);
    // back-to-back: entry on the cycle after exit
    cyc(1,'h6000,'hA0,1,31,0, 0,0,0,0, 0,0,0);
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'hA0,0);
    idle(1, 0);
    cyc(0,0,0,0,0,0, 1,'h7000,'hB0,0, 0,0,1);              // R1 re-entry from normal
    cyc(0,0,0,0,0,0, 0,0,0,0, 1,'hB0,1);
    idle(3, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule